// File: doc/BRIEF.md
# NAND Page Hamming Code Accumulator

This block builds a 24-bit Hamming-style parity code over one fixed-size chunk of NAND page data (512 bytes by default) while the data bytes stream past. The same code is produced on a page write, where it is stored in the spare area, and on a page read, where it is compared with the stored copy. Software starts a chunk by writing a config word with its enable bit set. This clears any earlier result. From then on, every data beat that carries the selected chip-select number is folded into twelve pairs of parity bits, one pair per address bit of the bit position inside the chunk. The code is not inverted, so a chunk of erased (all 0xFF) bytes gives an all-zero code.

A small state machine sets the flow. **ST_IDLE** is the state after reset and after a config write with the enable bit clear. **ST_RUN** accumulates. **ST_DONE** is entered once the configured number of bytes has been taken in. The transitions are named as follows. *start* is a config write with enable set, taken from any state to ST_RUN; it clears the accumulators and the byte counter. *stop* is a config write with enable clear, taken from any state to ST_IDLE; it keeps the result. *finish* goes from ST_RUN to ST_DONE when an accepted beat brings the count to the chunk size. In ST_IDLE and ST_DONE no beat changes the result.

On a 16-bit bus each beat carries two bytes, handled in little-endian order. The packed 32-bit result and the three spare bytes derived from it are presented on ports.

Top module: `nand_hecc_gen`

## Requirements
- R1: After reset the result and spare code are zero, and done and running are low.
- R2: A config write (cfg_we high) with cfg_word[0]=1 clears the result and the byte counter in the next cycle and enters ST_RUN. It latches the chip-select number from cfg_word[3:1] and the 16-bit-bus flag from cfg_word[7].
- R3: Each data bit has a 12-bit address {byte index (9 bits), bit position (3 bits)}, with the bit position in address bits 2:0. For every address bit k, the odd parity is the XOR of all data bits whose address bit k is 1, and the even parity is the XOR of those whose address bit k is 0. A chunk of all-0xFF bytes gives a zero result.
- R4: result[16+k] holds the odd parity and result[k] holds the even parity of address bit k (k = 0..11). result[15:12] and result[31:28] are zero.
- R5: spare_code[7:0] = result[7:0], spare_code[15:8] = result[23:16], spare_code[23:16] = {result[27:24], result[11:8]}.
- R6: A beat is accepted only in ST_RUN with beat_valid high and beat_cs equal to the latched chip select. Any other beat leaves the result unchanged. An accepted beat shows in the result one cycle later.
- R7: On an 8-bit bus a beat supplies beat_data[7:0] as byte n and the counter advances by 1. On a 16-bit bus beat_data[7:0] is byte n, beat_data[15:8] is byte n+1, and the counter advances by 2.
- R8: done is high for exactly one cycle, the cycle after the beat that completes the chunk. running is high only in ST_RUN and drops in that same cycle.
- R9: After the chunk is complete, further beats are ignored until the next start write.
- R10: A config write with cfg_word[0]=0 stops accumulation and keeps the result. Beats that follow are ignored.
- R11: When a config write and a beat arrive in the same cycle, the beat is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Config word write strobe |
| cfg_word | input | 8 | Config: bit0 enable, bits 3:1 chip select, bit7 16-bit bus |
| beat_valid | input | 1 | Data beat present |
| beat_cs | input | 3 | Chip-select number of the beat |
| beat_data | input | 16 | Beat data (low byte first) |
| result | output | 32 | Packed parity pairs |
| spare_code | output | 24 | Three spare-area bytes, byte0 in bits 7:0 |
| done | output | 1 | One-cycle chunk-complete pulse |
| running | output | 1 | High in ST_RUN |

## Verification
Assertions inside the RTL check these on every cycle: done lasts one cycle and coincides with ST_DONE; the counter never passes the chunk size; a start write leaves the result at zero; and the result stays frozen in ST_DONE and across a stop write. Only the bench can show that the parity values are correct for a given data stream, including byte ordering on the 16-bit bus and the address pattern of a single flipped bit. It does this with a behavioural per-bit model that is compared every clock, plus directed checks on erased chunks, chip-select filtering, mid-chunk stop and restart, and a write that collides with a beat.

// File: rtl/nand_hecc_pkg.sv
package nand_hecc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } hecc_state_e;

    localparam int CFG_EN_BIT   = 0;
    localparam int CFG_CS_LSB   = 1;
    localparam int CFG_WIDE_BIT = 7;
    localparam int BIT_ADDR_W   = 3;
    localparam int HALF_W       = 16;

endpackage

// File: rtl/hecc_byte_term.sv
module hecc_byte_term #(
    parameter int ADDR_W = 9,
    localparam int PAIRS = ADDR_W + nand_hecc_pkg::BIT_ADDR_W
) (
    input  logic [ADDR_W-1:0] byte_idx,
    input  logic [7:0]        byte_val,
    output logic [PAIRS-1:0]  odd_term,
    output logic [PAIRS-1:0]  even_term
);
    import nand_hecc_pkg::*;

    logic byte_par;

    always_comb begin
        byte_par  = ^byte_val;
        odd_term  = '0;
        even_term = '0;
        for (int b = 0; b < 8; b++) begin
            for (int k = 0; k < BIT_ADDR_W; k++) begin
                if (((b >> k) & 1) != 0)
                    odd_term[k] = odd_term[k] ^ byte_val[b];
                else
                    even_term[k] = even_term[k] ^ byte_val[b];
            end
        end
        for (int k = 0; k < ADDR_W; k++) begin
            odd_term[BIT_ADDR_W + k]  = byte_idx[k] & byte_par;
            even_term[BIT_ADDR_W + k] = ~byte_idx[k] & byte_par;
        end
    end

endmodule

// File: rtl/hecc_ctrl_fsm.sv
module hecc_ctrl_fsm #(
    parameter int CHUNK_BYTES = 512,
    parameter int CS_W        = 3,
    localparam int ADDR_W     = $clog2(CHUNK_BYTES),
    localparam int CNT_W      = ADDR_W + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [7:0]                 cfg_word,
    input  logic                       beat_valid,
    input  logic [CS_W-1:0]            beat_cs,
    output nand_hecc_pkg::hecc_state_e state_q,
    output logic                       start,
    output logic                       accept,
    output logic                       wide_q,
    output logic [ADDR_W-1:0]          base_idx,
    output logic                       done_q
);
    import nand_hecc_pkg::*;

    localparam logic [CNT_W-1:0] CHUNK_C = CNT_W'(CHUNK_BYTES);

    hecc_state_e      state_d;
    logic [CS_W-1:0]  cs_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] step;
    logic [CNT_W-1:0] cnt_next;
    logic             last;

    assign start    = cfg_we & cfg_word[CFG_EN_BIT];
    assign accept   = (state_q == ST_RUN) & beat_valid & ~cfg_we & (beat_cs == cs_q);
    assign step     = wide_q ? CNT_W'(2) : CNT_W'(1);
    assign cnt_next = cnt_q + step;
    assign last     = (cnt_next >= CHUNK_C);
    assign base_idx = cnt_q[ADDR_W-1:0];

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (cfg_we) begin
            state_d = cfg_word[CFG_EN_BIT] ? ST_RUN : ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_RUN:  if (accept && last) state_d = ST_DONE;
                ST_DONE: state_d = ST_DONE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs and counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q   <= '0;
            wide_q <= 1'b0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= accept & last;
            if (start) begin
                cs_q   <= cfg_word[CFG_CS_LSB +: CS_W];
                wide_q <= cfg_word[CFG_WIDE_BIT];
                cnt_q  <= '0;
            end else if (accept) begin
                cnt_q  <= cnt_next;
            end
        end
    end

    // R8
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R8
    done_in_done_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (state_q == ST_DONE));

    // R9
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CHUNK_C);

endmodule

// File: rtl/hecc_result_pack.sv
module hecc_result_pack #(
    parameter int PAIRS = 12
) (
    input  logic [PAIRS-1:0] odd_acc,
    input  logic [PAIRS-1:0] even_acc,
    output logic [31:0]      result,
    output logic [23:0]      spare_code
);
    import nand_hecc_pkg::*;

    always_comb begin
        result = '0;
        result[0 +: PAIRS]      = even_acc;
        result[HALF_W +: PAIRS] = odd_acc;
        spare_code = {result[27:24], result[11:8], result[23:16], result[7:0]};
    end

endmodule

// File: rtl/nand_hecc_gen.sv
module nand_hecc_gen #(
    parameter int CHUNK_BYTES = 512,
    parameter int CS_W        = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [7:0]      cfg_word,
    input  logic            beat_valid,
    input  logic [CS_W-1:0] beat_cs,
    input  logic [15:0]     beat_data,
    output logic [31:0]     result,
    output logic [23:0]     spare_code,
    output logic            done,
    output logic            running
);
    import nand_hecc_pkg::*;

    localparam int ADDR_W = $clog2(CHUNK_BYTES);
    localparam int PAIRS  = ADDR_W + BIT_ADDR_W;
    localparam int LANES  = 2;

    hecc_state_e       state_q;
    logic              start;
    logic              accept;
    logic              wide_q;
    logic [ADDR_W-1:0] base_idx;
    logic [PAIRS-1:0]  odd_q, even_q;
    logic [PAIRS-1:0]  lane_odd  [LANES];
    logic [PAIRS-1:0]  lane_even [LANES];
    logic [PAIRS-1:0]  sum_odd, sum_even;

    hecc_ctrl_fsm #(.CHUNK_BYTES(CHUNK_BYTES), .CS_W(CS_W)) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_word   (cfg_word),
        .beat_valid (beat_valid),
        .beat_cs    (beat_cs),
        .state_q    (state_q),
        .start      (start),
        .accept     (accept),
        .wide_q     (wide_q),
        .base_idx   (base_idx),
        .done_q     (done)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        hecc_byte_term #(.ADDR_W(ADDR_W)) i_term (
            .byte_idx  (base_idx + ADDR_W'(g)),
            .byte_val  (beat_data[8*g +: 8]),
            .odd_term  (lane_odd[g]),
            .even_term (lane_even[g])
        );
    end

    always_comb begin
        sum_odd  = lane_odd[0];
        sum_even = lane_even[0];
        if (wide_q) begin
            sum_odd  = sum_odd ^ lane_odd[1];
            sum_even = sum_even ^ lane_even[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            odd_q  <= '0;
            even_q <= '0;
        end else if (start) begin
            odd_q  <= '0;
            even_q <= '0;
        end else if (accept) begin
            odd_q  <= odd_q ^ sum_odd;
            even_q <= even_q ^ sum_even;
        end
    end

    hecc_result_pack #(.PAIRS(PAIRS)) i_pack (
        .odd_acc    (odd_q),
        .even_acc   (even_q),
        .result     (result),
        .spare_code (spare_code)
    );

    assign running = (state_q == ST_RUN);

    // R2
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_word[0]) |=> (result == 32'd0));

    // R9
    frozen_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && !cfg_we) |=> $stable(result));

    // R10
    stop_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_word[0]) |=> $stable(result));

endmodule

// File: tb/test_nand_hecc_gen.sv
module test_nand_hecc_gen;

    localparam int CLK_PERIOD = 10;
    localparam int CHUNK      = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_word = '0;
    logic        beat_valid = 1'b0;
    logic [2:0]  beat_cs = '0;
    logic [15:0] beat_data = '0;
    logic [31:0] result;
    logic [23:0] spare_code;
    logic        done;
    logic        running;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;
    int done_seen = 0;

    // behavioural reference state
    int        m_mode = 0;   // 0 stopped, 1 running, 2 complete
    int        m_cnt  = 0;
    int        m_cs   = 0;
    bit        m_wide = 0;
    bit        m_done = 0;
    bit [11:0] m_odd  = '0;
    bit [11:0] m_even = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_hecc_gen i_nand_hecc_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_word   (cfg_word),
        .beat_valid (beat_valid),
        .beat_cs    (beat_cs),
        .beat_data  (beat_data),
        .result     (result),
        .spare_code (spare_code),
        .done       (done),
        .running    (running)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // fold one byte into the model bit by bit (R3)
    task automatic model_byte(input int idx, input bit [7:0] v);
        for (int b = 0; b < 8; b++) begin
            if (v[b]) begin
                int addr = idx * 8 + b;
                for (int k = 0; k < 12; k++) begin
                    if (((addr >> k) & 1) != 0) m_odd[k]  = ~m_odd[k];
                    else                        m_even[k] = ~m_even[k];
                end
            end
        end
    endtask

    function automatic logic [31:0] exp_result();
        return {4'b0, m_odd, 4'b0, m_even};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_cs = 0; m_wide = 0; m_done = 0;
            m_odd = '0; m_even = '0;
        end else begin
            m_done = 0;
            if (cfg_we) begin
                if (cfg_word[0]) begin
                    m_mode = 1; m_cnt = 0; m_odd = '0; m_even = '0;
                    m_cs = int'(cfg_word[3:1]); m_wide = cfg_word[7];
                end else begin
                    m_mode = 0;
                end
            end else if (m_mode == 1 && beat_valid && int'(beat_cs) == m_cs) begin
                model_byte(m_cnt, beat_data[7:0]);
                if (m_wide) model_byte(m_cnt + 1, beat_data[15:8]);
                m_cnt += m_wide ? 2 : 1;
                if (m_cnt >= CHUNK) begin
                    m_mode = 2; m_done = 1;
                end
            end
        end
    end

    // compare with the model on every clock
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [31:0] er;
            er = exp_result();
            check("R3/R4 result", result, er);
            check("R5 spare", {8'h0, spare_code}, {8'h0, er[27:24], er[11:8], er[23:16], er[7:0]});
            check("R8 done", {31'b0, done}, {31'b0, m_done});
            check("R8 running", {31'b0, running}, {31'b0, m_mode == 1});
            if (done) done_seen++;
        end
    end

    task automatic cfg_write(input logic [7:0] w);
        cfg_we = 1'b1; cfg_word = w;
        @(negedge clk);
        cfg_we = 1'b0; cfg_word = '0;
    endtask

    task automatic send(input logic [15:0] d, input logic [2:0] cs);
        beat_valid = 1'b1; beat_data = d; beat_cs = cs;
        @(negedge clk);
        beat_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        logic [31:0] held;
        lfsr = 16'hACE1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 result", result, 32'h0);
        check("R1 flags", {30'b0, done, running}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: erased chunk, 8-bit bus, chip select 2
        cfg_write(8'h05);
        done_seen = 0;
        for (int i = 0; i < CHUNK; i++) send(16'h00FF, 3'd2);
        @(negedge clk);
        check("R3 erased zero", result, 32'h0);
        check("R8 one done pulse", done_seen, 1);

        // R4/R5: single cleared bit at byte 300 bit 5
        cfg_write(8'h05);
        for (int i = 0; i < CHUNK; i++) send((i == 300) ? 16'h00DF : 16'h00FF, 3'd2);
        @(negedge clk);
        check("R4 flip address", result, 32'h0965_069A);
        check("R5 spare bytes", {8'h0, spare_code}, 32'h0096_659A);
        // R9: beats after completion ignored
        send(16'h1234, 3'd2);
        send(16'h00A5, 3'd2);
        @(negedge clk);
        check("R9 ignored after done", result, 32'h0965_069A);

        // R6/R7: 16-bit bus, chip select 1, foreign beats interleaved
        cfg_write(8'h83);
        for (int i = 0; i < 100; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send(lfsr, 3'd1);
            send(~lfsr, 3'd3);
            if (i % 7 == 0) @(negedge clk);
        end
        // R10: stop keeps result, beats ignored
        held = result;
        cfg_write(8'h00);
        send(16'hFFFF, 3'd1);
        send(16'h0F0F, 3'd1);
        check("R10 stop holds", result, held);
        // R2: restart clears
        cfg_write(8'h83);
        check("R2 restart clears", result, 32'h0);
        // R11: config write colliding with a beat drops the beat
        cfg_we = 1'b1; cfg_word = 8'h83;
        beat_valid = 1'b1; beat_data = 16'h0001; beat_cs = 3'd1;
        @(negedge clk);
        cfg_we = 1'b0; beat_valid = 1'b0;
        check("R11 beat dropped", result, 32'h0);
        done_seen = 0;
        for (int i = 0; i < CHUNK / 2; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send(lfsr, 3'd1);
        end
        @(negedge clk);
        check("R7 wide chunk done once", done_seen, 1);
        held = result;
        send(16'hBEEF, 3'd1);
        check("R9 wide ignored after done", result, held);

        // R7: 16-bit erased chunk also yields zero
        cfg_write(8'h83);
        for (int i = 0; i < CHUNK / 2; i++) send(16'hFFFF, 3'd1);
        @(negedge clk);
        check("R7 wide erased zero", result, 32'h0);
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule